// File: doc/BRIEF.md
# Two-stage fused multiply-add fraction datapath

This block forms X*Y + Z on unsigned 56-bit fractions and delivers a normalised 56-bit result two clock edges after the operands are presented. X is recoded into radix-4 signed digits. Each digit selects zero, Y, 2Y or the complement of one of these. The resulting rows are compressed by a carry-save tree together with Z as one more input row. Z is first placed inside a 112-bit window by a left shift of `z_shift` bit positions.

The tree brings the 30 rows down to three vectors, and these are registered. In the second stage a single 3:2 row turns them into two vectors. A carry-propagate adder then forms the 112-bit sum. A leading-zero count moves the most significant one of the sum to the top bit, and the upper 56 bits are the result. A valid bit travels alongside the data, so a new operation may be issued on every cycle. Exponents, rounding and signs are handled outside this block.

Top module: `fma56_pipe`

## Requirements
- R1: With S = (X*Y + (Z << z_shift)) mod 2^112 and S nonzero, `out_frac` equals bits 111..56 of S shifted left until bit 111 is one, so `out_frac[55]` is 1.
- R2: For a nonzero S, `out_lzc` equals the number of zero bits above the most significant one of S (0 to 111), and `out_zero` is 0.
- R3: When S is zero, `out_frac` is 0, `out_lzc` is 0 and `out_zero` is 1.
- R4: Shift amount 0 aligns Z bit 0 with product bit 0. Z bits pushed above bit 111 are discarded, and any shift of 112 or more removes Z from the sum.
- R5: `out_valid` is high exactly two rising edges after `in_valid` was sampled high. Operations issued on consecutive cycles each give their own result on consecutive cycles.
- R6: While `out_valid` is low after an operation, `out_frac`, `out_lzc` and `out_zero` keep their last values whatever the inputs do.
- R7: After reset, `out_valid`, `out_frac`, `out_lzc` and `out_zero` are all 0.
- R8: A sum that exceeds 2^112 - 1 wraps modulo 2^112 before normalisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on this cycle form an operation |
| op_x | input | 56 | Multiplier, Booth recoded |
| op_y | input | 56 | Multiplicand |
| op_z | input | 56 | Addend |
| z_shift | input | 7 | Left shift applied to the addend |
| out_valid | output | 1 | Result registers hold a new result |
| out_frac | output | 56 | Normalised upper fraction bits |
| out_lzc | output | 7 | Left shift used by normalisation |
| out_zero | output | 1 | Sum was zero |

## Verification
Stage 1 compresses a new operation on the same edge that stage 2 adds and normalises the previous one, so a fault in the pipeline register or the valid tracking would mix neighbouring operations. The bench streams operations on every cycle. Zero sums, wrapping sums, extreme shifts and all-ones operands sit next to ordinary ones in that stream. Each output is compared, exactly two cycles after its issue, with a reference computed from that operation alone.

// File: rtl/fma56_pipe.sv
module fma56_pipe #(
  parameter int W = 56,
  localparam int PW = 2 * W,
  localparam int SHW = $clog2(PW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   op_x,
  input  logic [W-1:0]   op_y,
  input  logic [W-1:0]   op_z,
  input  logic [SHW-1:0] z_shift,
  output logic           out_valid,
  output logic [W-1:0]   out_frac,
  output logic [SHW-1:0] out_lzc,
  output logic           out_zero
);
  localparam int NPP = W / 2 + 1;
  localparam int NT  = NPP + 1;

  function automatic int lvl_cnt(int l);
    int n;
    n = NT;
    for (int k = 0; k < l; k++) n = 2 * (n / 3) + n % 3;
    return n;
  endfunction

  function automatic int num_lv();
    int n;
    int c;
    n = NT;
    c = 0;
    while (n > 3) begin
      n = 2 * (n / 3) + n % 3;
      c++;
    end
    return c;
  endfunction

  localparam int LV = num_lv();

  // Stage 1: Booth recoding of X, row generation, aligned addend
  logic [W+2:0]  xe;
  logic [NPP-1:0] neg_d;
  logic [PW-1:0] lv [LV+1][NT];

  assign xe = {2'b00, op_x, 1'b0};

  genvar i, l, j;
  generate
    for (i = 0; i < NPP; i++) begin : g_row
      logic [2:0]   trip;
      logic         one, two;
      logic [W:0]   mag, sel;
      logic [PW-1:0] ext;
      assign trip = xe[2*i+2 -: 3];
      assign one  = (trip == 3'b001) || (trip == 3'b010) ||
                    (trip == 3'b101) || (trip == 3'b110);
      assign two  = (trip == 3'b011) || (trip == 3'b100);
      assign neg_d[i] = trip[2] & ~(trip == 3'b111);
      assign mag  = two ? {op_y, 1'b0} : (one ? {1'b0, op_y} : '0);
      assign sel  = neg_d[i] ? ~mag : mag;
      assign ext  = {{(PW-W-1){neg_d[i]}}, sel};
      if (i == 0) begin : g_first
        assign lv[0][i] = ext;
      end else begin : g_rest
        // correction +1 of the previous negative row sits below this row's data
        assign lv[0][i] = (ext << (2*i)) |
                          ({{(PW-1){1'b0}}, neg_d[i-1]} << (2*i-2));
      end
    end
  endgenerate

  assign lv[0][NT-1] = {{(PW-W){1'b0}}, op_z} << z_shift;

  // Carry-save compression, level by level, down to three vectors
  generate
    for (l = 0; l < LV; l++) begin : g_lv
      localparam int N  = lvl_cnt(l);
      localparam int NG = N / 3;
      localparam int NO = 2 * NG + N % 3;
      for (j = 0; j < NG; j++) begin : g_csa
        logic [PW-1:0] a, b, c;
        assign a = lv[l][3*j];
        assign b = lv[l][3*j+1];
        assign c = lv[l][3*j+2];
        assign lv[l+1][2*j]   = a ^ b ^ c;
        assign lv[l+1][2*j+1] = ((a & b) | (a & c) | (b & c)) << 1;
      end
      for (j = 0; j < N % 3; j++) begin : g_pass
        assign lv[l+1][2*NG+j] = lv[l][3*NG+j];
      end
      for (j = NO; j < NT; j++) begin : g_pad
        assign lv[l+1][j] = '0;
      end
    end
  endgenerate

  // Pipeline register at the three-vector boundary
  logic          s1_v;
  logic [PW-1:0] s1_a, s1_b, s1_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_a <= '0;
      s1_b <= '0;
      s1_c <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_a <= lv[LV][0];
        s1_b <= lv[LV][1];
        s1_c <= lv[LV][2];
      end
    end
  end

  // Stage 2: 3:2 row, carry-propagate add, renormalise
  function automatic logic [SHW-1:0] lead_zeros(logic [PW-1:0] v);
    logic [SHW-1:0] cnt;
    cnt = '0;
    for (int k = 0; k < PW; k++)
      if (v[k]) cnt = SHW'(PW - 1 - k);
    return cnt;
  endfunction

  logic [PW-1:0]  row_s, row_c, sum, norm;
  logic [SHW-1:0] lz;
  logic           is_zero;

  assign row_s   = s1_a ^ s1_b ^ s1_c;
  assign row_c   = ((s1_a & s1_b) | (s1_a & s1_c) | (s1_b & s1_c)) << 1;
  assign sum     = row_s + row_c;
  assign is_zero = (sum == '0);
  assign lz      = lead_zeros(sum);
  assign norm    = sum << lz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_frac  <= '0;
      out_lzc   <= '0;
      out_zero  <= 1'b0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) begin
        out_frac <= norm[PW-1 -: W];
        out_lzc  <= lz;
        out_zero <= is_zero;
      end
    end
  end

  assert_tree_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |-> (s1_a + s1_b + s1_c) ==
      $past(({{W{1'b0}}, op_x} * {{W{1'b0}}, op_y}) +
            ({{W{1'b0}}, op_z} << z_shift)));

  assert_norm_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_zero) |-> out_frac[W-1]);

  assert_zero_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (out_frac == '0 && out_lzc == '0));

  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(s1_v));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_frac) && $stable(out_lzc) && $stable(out_zero)));
endmodule

// File: tb/fma56_pipe_tb.sv
`timescale 1ns/1ps
module fma56_pipe_tb;
  localparam int W = 56;
  localparam int PW = 112;
  localparam int SHW = 7;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [W-1:0] op_x = '0, op_y = '0, op_z = '0;
  logic [SHW-1:0] z_shift = '0;
  logic out_valid;
  logic [W-1:0] out_frac;
  logic [SHW-1:0] out_lzc;
  logic out_zero;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fma56_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_x(op_x), .op_y(op_y), .op_z(op_z), .z_shift(z_shift),
    .out_valid(out_valid), .out_frac(out_frac),
    .out_lzc(out_lzc), .out_zero(out_zero)
  );

  typedef struct packed {
    logic [W-1:0]   frac;
    logic [SHW-1:0] lzc;
    logic           zero;
  } exp_t;

  function automatic exp_t model(logic [W-1:0] x, logic [W-1:0] y,
                                 logic [W-1:0] z, logic [SHW-1:0] s);
    logic [PW-1:0] t, n;
    exp_t e;
    int msb;
    t = ({{W{1'b0}}, x} * {{W{1'b0}}, y}) + ({{W{1'b0}}, z} << s);
    msb = -1;
    for (int k = PW - 1; k >= 0; k--)
      if (t[k] && msb < 0) msb = k;
    if (msb < 0) begin
      e.frac = '0; e.lzc = '0; e.zero = 1'b1;
    end else begin
      n = t << (PW - 1 - msb);
      e.frac = n[PW-1 -: W];
      e.lzc = SHW'(PW - 1 - msb);
      e.zero = 1'b0;
    end
    return e;
  endfunction

  task automatic check(string req, bit ok, string act, string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic check_out(string req, exp_t e);
    check(req, out_valid === 1'b1 && out_frac === e.frac &&
               out_lzc === e.lzc && out_zero === e.zero,
          $sformatf("v=%b f=%h l=%0d z=%b", out_valid, out_frac, out_lzc, out_zero),
          $sformatf("v=1 f=%h l=%0d z=%b", e.frac, e.lzc, e.zero));
  endtask

  task automatic one_op(string req, logic [W-1:0] x, logic [W-1:0] y,
                        logic [W-1:0] z, logic [SHW-1:0] s);
    exp_t e;
    e = model(x, y, z, s);
    @(negedge clk);
    op_x = x; op_y = y; op_z = z; z_shift = s; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check({req, " early"}, out_valid === 1'b0, $sformatf("%b", out_valid), "0");
    @(negedge clk);
    check_out(req, e);
  endtask

  task automatic t_reset();
    check("R7", out_valid === 0 && out_frac === '0 && out_lzc === '0 && out_zero === 0,
          $sformatf("v=%b f=%h l=%0d z=%b", out_valid, out_frac, out_lzc, out_zero),
          "all zero");
  endtask

  task automatic t_directed();
    one_op("R1 all-ones", '1, '1, '0, 0);
    one_op("R2 unit", 56'd1, 56'd1, '0, 0);
    one_op("R3 zero", '0, 56'h123456789abcde, '0, 5);
    one_op("R3 zero shifted out", 56'h0, 56'h1, 56'hff, 7'd112);
    one_op("R4 max shift", 56'd3, 56'd5, '1, 7'd111);
    one_op("R4 beyond window", 56'd3, 56'd5, '1, 7'd127);
    one_op("R4 zero shift", 56'd0, 56'd9, 56'hf0f0, 0);
    one_op("R8 wrap", '1, '1, '1, 7'd56);
    one_op("R1 booth pattern", 56'haaaaaaaaaaaaaa, 56'h55555555555555, 56'h1, 3);
  endtask

  task automatic t_hold();
    logic [W-1:0] f; logic [SHW-1:0] lz; logic zf;
    one_op("R6 setup", 56'h7, 56'h9, 56'h2, 1);
    f = out_frac; lz = out_lzc; zf = out_zero;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      op_x = '1; op_y = 56'h3; op_z = '1; z_shift = 7'd20;
    end
    @(negedge clk);
    check("R6", out_valid === 0 && out_frac === f && out_lzc === lz && out_zero === zf,
          $sformatf("v=%b f=%h l=%0d", out_valid, out_frac, out_lzc),
          $sformatf("v=0 f=%h l=%0d", f, lz));
  endtask

  task automatic t_stream();
    localparam int N = 40;
    logic [W-1:0] xs [N], ys [N], zs [N];
    logic [SHW-1:0] ss [N];
    for (int k = 0; k < N; k++) begin
      xs[k] = {$urandom, $urandom};
      ys[k] = {$urandom, $urandom};
      zs[k] = {$urandom, $urandom};
      ss[k] = SHW'($urandom);
      if (k % 7 == 3) begin xs[k] = '0; zs[k] = '0; end
      if (k % 9 == 4) begin xs[k] = '1; ys[k] = '1; zs[k] = '1; ss[k] = 7'd111; end
      if (k % 11 == 5) begin ys[k] = '0; ss[k] = 7'd120; end
    end
    for (int k = 0; k < N + 2; k++) begin
      @(negedge clk);
      if (k >= 2) check_out($sformatf("R5 stream op %0d", k - 2),
                            model(xs[k-2], ys[k-2], zs[k-2], ss[k-2]));
      if (k < N) begin
        op_x = xs[k]; op_y = ys[k]; op_z = zs[k]; z_shift = ss[k]; in_valid = 1;
      end else in_valid = 0;
    end
    @(negedge clk);
    check("R5 drain", out_valid === 0, $sformatf("%b", out_valid), "0");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_directed();
    t_hold();
    t_stream();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule